// File: doc/BRIEF.md
# Streaming Packet Firewall Classifier

This block inspects a packet stream that arrives one byte per clock on an 8-bit bus. A valid strobe qualifies each byte. The block follows the frame through its fields in order: a start marker, a source address, a destination address, a type code, a length byte, a payload whose size the length byte gives, and a final checksum byte. It keeps the header fields it will need later. It folds every header and payload byte into a running XOR. It counts the payload down so that it knows which byte is the checksum.

When the checksum byte has been consumed, the block reports one verdict on the next cycle: accept, drop or invalid, together with a done flag. Format faults always win over policy faults. A packet that is well formed but breaks a fixed rule is dropped. All rules are constants, and nothing is stored or forwarded beyond the verdict. Packets may follow one another with no idle cycle between them. The reset is synchronous and active high.

Top module: `fw_packet_filter`

## Requirements
- R1: A frame is 0xAA, SRC, DST, TYPE, LEN, LEN payload bytes, then one checksum byte, for 6 + LEN bytes in all; the stream AA,05,10,01,02,11,22,25 yields accept.
- R2: A cycle with valid_in low consumes nothing. Frame position, captured fields and checksum hold, so idle gaps anywhere inside a frame leave the verdict unchanged.
- R3: The expected checksum is the XOR of SRC, DST, TYPE, LEN and all payload bytes, leaving out the 0xAA marker. A final byte that differs gives invalid.
- R4: TYPE outside {0x01, 0x02, 0x03}, or LEN above 8, gives invalid. The block still consumes LEN payload bytes (any value up to 255) and the checksum byte before reporting.
- R5: TYPE 0x02 with nonzero LEN, or TYPE 0x01 with LEN zero, gives invalid. With LEN zero the byte after LEN is the checksum.
- R6: A well-formed packet is dropped when SRC is 0xE0 or 0xE1, or DST is none of 0x10, 0x20, 0x30, or TYPE is 0x03 while SRC is not 0x01. Otherwise it is accepted. Any format fault yields invalid even when a policy rule is also broken.
- R7: The verdict appears in the cycle after the last byte is consumed. Exactly one of accept, drop, invalid is high together with done for that one cycle. All four are low in every other cycle.
- R8: A consumed byte other than 0xAA while waiting for a frame gives an invalid-plus-done pulse on the next cycle. The block keeps waiting for a marker.
- R9: A 0xAA presented in the cycle in which a verdict is pulsed starts a new frame, so back-to-back packets are each classified.
- R10: A synchronous active-high reset abandons any partial frame and clears all captured state. The four outputs are low on the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Byte on data_in is consumed this cycle |
| data_in | input | 8 | Stream byte |
| accept | output | 1 | Packet passed all rules |
| drop | output | 1 | Well-formed packet blocked by a rule |
| invalid | output | 1 | Malformed frame |
| done | output | 1 | Verdict cycle |

## Verification
The bench builds the block with its defaults: 8-bit bytes and a payload limit of 8. With that limit, lengths of 8, 9 and 12 all fit in short runs. A full-size legal payload and over-limit lengths that must still be walked byte by byte can both be tried. The 8-bit length counter also makes a 255-byte walk reachable, and the bench sends one after a bad type. A behavioural model compares every cycle, so back-to-back frames, marker errors directly after a verdict, and idle gaps at every frame position are judged as precisely as the verdicts themselves.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int BYTE_W      = 8;
  localparam int N_DST_OK    = 3;
  localparam int N_SRC_BLOCK = 2;

  localparam logic [BYTE_W-1:0] MARKER    = 8'hAA;
  localparam logic [BYTE_W-1:0] T_DATA    = 8'h01;
  localparam logic [BYTE_W-1:0] T_PING    = 8'h02;
  localparam logic [BYTE_W-1:0] T_CTRL    = 8'h03;
  localparam logic [BYTE_W-1:0] ADMIN_SRC = 8'h01;

  localparam logic [BYTE_W-1:0] DST_OK    [N_DST_OK]    = '{8'h10, 8'h20, 8'h30};
  localparam logic [BYTE_W-1:0] SRC_BLOCK [N_SRC_BLOCK] = '{8'hE0, 8'hE1};

  typedef enum logic [2:0] {
    ST_WAIT, ST_SRC, ST_DST, ST_TYP, ST_LEN, ST_PAY, ST_CHK
  } walk_e;

  typedef struct packed {
    logic [BYTE_W-1:0] src;
    logic [BYTE_W-1:0] dst;
    logic [BYTE_W-1:0] typ;
    logic [BYTE_W-1:0] len;
  } hdr_t;
endpackage

// File: rtl/fw_frame_walker.sv
module fw_frame_walker
  import fw_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic [W-1:0] data_in,
  output logic         cap_src,
  output logic         cap_dst,
  output logic         cap_typ,
  output logic         cap_len,
  output logic         acc_load,
  output logic         acc_fold,
  output logic         frame_end,
  output logic         marker_bad
);
  walk_e        state_q, state_d;
  logic [W-1:0] left_q, left_d;
  logic         state_en, left_en;

  always_comb begin
    state_d    = state_q;
    left_d     = left_q;
    left_en    = 1'b0;
    cap_src    = 1'b0;
    cap_dst    = 1'b0;
    cap_typ    = 1'b0;
    cap_len    = 1'b0;
    acc_load   = 1'b0;
    acc_fold   = 1'b0;
    frame_end  = 1'b0;
    marker_bad = 1'b0;
    if (valid_in) begin
      case (state_q)
        ST_WAIT: begin
          if (data_in == MARKER) state_d = ST_SRC;
          else                   marker_bad = 1'b1;
        end
        ST_SRC: begin
          cap_src  = 1'b1;
          acc_load = 1'b1;
          state_d  = ST_DST;
        end
        ST_DST: begin
          cap_dst  = 1'b1;
          acc_fold = 1'b1;
          state_d  = ST_TYP;
        end
        ST_TYP: begin
          cap_typ  = 1'b1;
          acc_fold = 1'b1;
          state_d  = ST_LEN;
        end
        ST_LEN: begin
          cap_len  = 1'b1;
          acc_fold = 1'b1;
          left_en  = 1'b1;
          left_d   = data_in;
          state_d  = (data_in == '0) ? ST_CHK : ST_PAY;
        end
        ST_PAY: begin
          acc_fold = 1'b1;
          left_en  = 1'b1;
          left_d   = left_q - 1'b1;
          state_d  = (left_q == W'(1)) ? ST_CHK : ST_PAY;
        end
        ST_CHK: begin
          frame_end = 1'b1;
          state_d   = ST_WAIT;
        end
        default: state_d = ST_WAIT;
      endcase
    end
  end

  assign state_en = valid_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      left_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (left_en)  left_q  <= left_d;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(state_q) && $stable(left_q)); // R2
  AST_PAY_COUNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_PAY |-> left_q != '0); // R4
endmodule

// File: rtl/fw_xor_accum.sv
module fw_xor_accum #(
  parameter int W = fw_pkg::BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         fold,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] sum
);
  logic [W-1:0] sum_q, sum_d;
  logic         sum_en;

  always_comb begin
    sum_d  = sum_q;
    sum_en = load | fold;
    if (load)      sum_d = data_in;
    else if (fold) sum_d = sum_q ^ data_in;
  end

  always_ff @(posedge clk) begin
    if (rst)         sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/fw_rule_check.sv
module fw_rule_check
  import fw_pkg::*;
#(
  parameter int W           = BYTE_W,
  parameter int MAX_PAYLOAD = 8
) (
  input  hdr_t         hdr,
  input  logic [W-1:0] sum,
  input  logic [W-1:0] chk_byte,
  output logic         malformed,
  output logic         blocked
);
  logic [N_DST_OK-1:0]    dst_hit;
  logic [N_SRC_BLOCK-1:0] src_hit;

  for (genvar i = 0; i < N_DST_OK; i++) begin : g_dst
    assign dst_hit[i] = (hdr.dst == DST_OK[i]);
  end
  for (genvar j = 0; j < N_SRC_BLOCK; j++) begin : g_src
    assign src_hit[j] = (hdr.src == SRC_BLOCK[j]);
  end

  logic type_known, len_over, ping_bad, data_bad, sum_bad;
  logic ctrl_bad;

  always_comb begin
    type_known = (hdr.typ == T_DATA) || (hdr.typ == T_PING) || (hdr.typ == T_CTRL);
    len_over   = hdr.len > W'(MAX_PAYLOAD);
    ping_bad   = (hdr.typ == T_PING) && (hdr.len != '0);
    data_bad   = (hdr.typ == T_DATA) && (hdr.len == '0);
    sum_bad    = sum != chk_byte;
    malformed  = !type_known || len_over || ping_bad || data_bad || sum_bad;
    ctrl_bad   = (hdr.typ == T_CTRL) && (hdr.src != ADMIN_SRC);
    blocked    = (|src_hit) || !(|dst_hit) || ctrl_bad;
  end
endmodule

// File: rtl/fw_packet_filter.sv
module fw_packet_filter
  import fw_pkg::*;
#(
  parameter int W           = BYTE_W,
  parameter int MAX_PAYLOAD = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic [W-1:0] data_in,
  output logic         accept,
  output logic         drop,
  output logic         invalid,
  output logic         done
);
  logic cap_src, cap_dst, cap_typ, cap_len;
  logic acc_load, acc_fold, frame_end, marker_bad;
  logic malformed, blocked;
  logic [W-1:0] sum;
  hdr_t hdr_q;

  fw_frame_walker #(.W(W)) u_walk (
    .clk(clk), .rst(rst), .valid_in(valid_in), .data_in(data_in),
    .cap_src(cap_src), .cap_dst(cap_dst), .cap_typ(cap_typ), .cap_len(cap_len),
    .acc_load(acc_load), .acc_fold(acc_fold),
    .frame_end(frame_end), .marker_bad(marker_bad)
  );

  fw_xor_accum #(.W(W)) u_sum (
    .clk(clk), .rst(rst), .load(acc_load), .fold(acc_fold),
    .data_in(data_in), .sum(sum)
  );

  fw_rule_check #(.W(W), .MAX_PAYLOAD(MAX_PAYLOAD)) u_rules (
    .hdr(hdr_q), .sum(sum), .chk_byte(data_in),
    .malformed(malformed), .blocked(blocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q <= '0;
    end else begin
      if (cap_src) hdr_q.src <= data_in;
      if (cap_dst) hdr_q.dst <= data_in;
      if (cap_typ) hdr_q.typ <= data_in;
      if (cap_len) hdr_q.len <= data_in;
    end
  end

  logic acc_d, drop_d, inv_d, done_d;
  always_comb begin
    done_d = marker_bad | frame_end;
    inv_d  = marker_bad | (frame_end & malformed);
    drop_d = frame_end & !malformed & blocked;
    acc_d  = frame_end & !malformed & !blocked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accept  <= 1'b0;
      drop    <= 1'b0;
      invalid <= 1'b0;
      done    <= 1'b0;
    end else begin
      accept  <= acc_d;
      drop    <= drop_d;
      invalid <= inv_d;
      done    <= done_d;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    $countones({accept, drop, invalid}) == (done ? 1 : 0)); // R7
  AST_VERDICT_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(valid_in)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !done && !accept && !drop && !invalid); // R10
endmodule

// File: tb/fw_packet_filter_test.sv
module fw_packet_filter_test;
  localparam int CLK_P = 10;
  typedef byte unsigned bq_t[$];

  logic clk = 1'b0;
  logic rst, valid_in;
  logic [7:0] data_in;
  logic accept, drop, invalid, done;

  fw_packet_filter uut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .data_in(data_in),
    .accept(accept), .drop(drop), .invalid(invalid), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   ended = 0;
  bq_t  frame_q;
  logic [3:0] exp_o;

  // 0 accept, 1 drop, 2 invalid
  function automatic int judge(bq_t p);
    byte unsigned x = 0;
    byte unsigned s = p[1], d = p[2], t = p[3], l = p[4];
    bit bad, pol;
    for (int i = 1; i < p.size() - 1; i++) x ^= p[i];
    bad = !(t >= 1 && t <= 3) || l > 8 || (t == 2 && l != 0) ||
          (t == 1 && l == 0) || x != p[p.size()-1];
    if (bad) return 2;
    pol = s == 8'hE0 || s == 8'hE1 || !(d == 8'h10 || d == 8'h20 || d == 8'h30) ||
          (t == 3 && s != 8'h01);
    return pol ? 1 : 0;
  endfunction

  function automatic bq_t mk(byte unsigned s, byte unsigned d, byte unsigned t,
                             byte unsigned l, byte unsigned seed, bit corrupt);
    bq_t p;
    byte unsigned x;
    p = '{8'hAA, s, d, t, l};
    x = s ^ d ^ t ^ l;
    for (int i = 0; i < int'(l); i++) begin
      p.push_back(byte'(seed + 8'(i * 7)));
      x ^= byte'(seed + 8'(i * 7));
    end
    p.push_back(corrupt ? byte'(x ^ 8'h40) : x);
    return p;
  endfunction

  task automatic compare(string tag);
    logic [3:0] got;
    got = {accept, drop, invalid, done};
    n_vec++;
    if (got !== exp_o) begin
      n_bad++;
      $display("FAIL %s at %0t: {acc,drop,inv,done} got %b expected %b", tag, $time, got, exp_o);
    end
  endtask

  task automatic step(bit v, byte unsigned b, string tag);
    valid_in = v;
    data_in  = b;
    @(posedge clk);
    exp_o = 4'b0000;
    if (v) begin
      if (frame_q.size() == 0) begin
        if (b != 8'hAA) exp_o = 4'b0011;
        else            frame_q.push_back(b);
      end else begin
        frame_q.push_back(b);
        if (frame_q.size() >= 5 && frame_q.size() == 6 + int'(frame_q[4])) begin
          case (judge(frame_q))
            0:       exp_o = 4'b1001;
            1:       exp_o = 4'b0101;
            default: exp_o = 4'b0011;
          endcase
          frame_q.delete();
        end
      end
    end
    #(CLK_P/4);
    compare(tag);
  endtask

  task automatic do_reset(string tag);
    rst = 1'b1;
    valid_in = 1'b0;
    @(posedge clk);
    @(posedge clk);
    frame_q.delete();
    exp_o = 4'b0000;
    #(CLK_P/4);
    compare(tag);
    rst = 1'b0;
    step(0, 8'h00, tag);
  endtask

  task automatic send(bq_t p, int gap_every, string tag);
    for (int i = 0; i < p.size(); i++) begin
      step(1, p[i], tag);
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) step(0, 8'h5A, tag);
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 8'hAA, tag);
  endtask

  task automatic finish_run();
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_bad++;
      $display("FAIL R7 watchdog: run did not end, got hang expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    valid_in = 1'b0;
    data_in = 8'h00;
    exp_o = 4'b0000;
    do_reset("R10 reset state");

    // R1: the worked example
    send('{8'hAA, 8'h05, 8'h10, 8'h01, 8'h02, 8'h11, 8'h22, 8'h25}, 0, "R1 example accept");
    idle(2, "R7 quiet after verdict");
    // R1: full legal payload
    send(mk(8'h07, 8'h30, 8'h01, 8'd8, 8'h3C, 0), 0, "R1 max payload");
    // R5: ping with no payload
    send(mk(8'h44, 8'h20, 8'h02, 8'd0, 8'h00, 0), 0, "R5 ping len0");
    send(mk(8'h44, 8'h20, 8'h02, 8'd2, 8'h10, 0), 0, "R5 ping with payload");
    send(mk(8'h44, 8'h20, 8'h01, 8'd0, 8'h00, 0), 0, "R5 data len0");
    // R6: policy
    send(mk(8'h01, 8'h10, 8'h03, 8'd1, 8'h77, 0), 0, "R6 admin control");
    send(mk(8'h02, 8'h10, 8'h03, 8'd1, 8'h77, 0), 0, "R6 non-admin control");
    send(mk(8'hE0, 8'h10, 8'h01, 8'd3, 8'h09, 0), 0, "R6 blocked src E0");
    send(mk(8'hE1, 8'h20, 8'h02, 8'd0, 8'h00, 0), 0, "R6 blocked src E1");
    send(mk(8'h05, 8'h40, 8'h01, 8'd2, 8'h01, 0), 0, "R6 bad dst");
    // R3: checksum mismatch outranks a policy fault
    send(mk(8'h05, 8'h10, 8'h01, 8'd2, 8'h11, 1), 0, "R3 bad checksum");
    send(mk(8'hE0, 8'h40, 8'h01, 8'd2, 8'h11, 1), 0, "R6 invalid over drop");
    // R4: malformed type or length, walked to the end
    send(mk(8'h05, 8'h10, 8'h07, 8'd3, 8'h21, 0), 0, "R4 unknown type");
    send(mk(8'h05, 8'h10, 8'h01, 8'd9, 8'h21, 0), 0, "R4 len 9");
    send(mk(8'h05, 8'h20, 8'h00, 8'd12, 8'h90, 0), 0, "R4 len 12 type 0");
    send(mk(8'h05, 8'h20, 8'hFF, 8'd255, 8'h03, 0), 0, "R4 len 255");
    // R8: stray bytes while waiting
    step(1, 8'h55, "R8 stray byte");
    step(1, 8'h00, "R8 second stray");
    idle(1, "R8 quiet");
    step(1, 8'hAB, "R8 third stray");
    send(mk(8'h05, 8'h30, 8'h01, 8'd1, 8'h0E, 0), 0, "R8 recovers");
    // R9: back-to-back frames, and a stray right after a verdict
    send(mk(8'h05, 8'h10, 8'h01, 8'd1, 8'h01, 0), 0, "R9 first");
    send(mk(8'h02, 8'h10, 8'h03, 8'd0, 8'h00, 0), 0, "R9 second");
    send(mk(8'h05, 8'h20, 8'h02, 8'd0, 8'h00, 0), 0, "R9 third");
    step(1, 8'h12, "R9 stray after verdict");
    send(mk(8'h05, 8'h30, 8'h01, 8'd4, 8'h50, 1), 0, "R9 after stray");
    // R2: idle gaps at every position
    send(mk(8'h05, 8'h10, 8'h01, 8'd5, 8'h61, 0), 1, "R2 gap every byte");
    send(mk(8'h01, 8'h30, 8'h03, 8'd2, 8'h62, 0), 2, "R2 gap every second");
    send(mk(8'hE1, 8'h30, 8'h01, 8'd3, 8'h63, 0), 3, "R2 gap drop");
    // R10: reset mid-frame
    begin
      bq_t p = mk(8'h05, 8'h10, 8'h01, 8'd6, 8'h70, 0);
      for (int i = 0; i < 7; i++) step(1, p[i], "R10 partial");
    end
    do_reset("R10 mid-frame reset");
    send(mk(8'h05, 8'h10, 8'h01, 8'd2, 8'h11, 0), 0, "R10 after reset");
    idle(3, "R7 final quiet");
    finish_run();
  end
endmodule